// File: doc/BRIEF.md
# Memory-to-Memory Block Copy Sequencer

This block copies a run of bytes from one memory region to another without processor involvement. It keeps two address channels. Channel 0 holds the source address and channel 1 holds the destination address. A single byte counter tracks the block length. Every byte takes two bus cycles. In the first cycle the block reads the source location into an internal 8-bit holding register. In the second cycle it writes that register to the destination location.

Software first pulses `load_i` to capture the start addresses, the byte count, the direction of each channel, an optional fixed-source mode and the auto-initialize choice. A pulse on `go_i` then runs the copy. When the counter reaches its terminal value the block raises `done_o` and `tc_o` for one cycle. If auto-initialize was selected, the block restores the loaded values and stays armed, so a later `go_i` repeats the same block. Otherwise the block disarms until the next load. An external end-of-process input `eop_i` stops the copy once the write of the current byte completes. The remaining state is kept, so a later `go_i` resumes the copy.

Top module: `m2m_copy_seq`

## Requirements
- R1: After reset `mem_rd_o`, `mem_wr_o`, `busy_o`, `done_o` and `tc_o` are low, and the block is disarmed: `go_i` produces no bus cycle until a `load_i` pulse has been accepted.
- R2: Each byte uses two consecutive cycles. In the first, `mem_rd_o`=1 and `mem_addr_o` is the source address. In the next, `mem_wr_o`=1, `mem_addr_o` is the destination address and `mem_wdata_o` equals the `mem_rdata_i` value seen during that read cycle. The two strobes are never high together.
- R3: After each read the source address moves by one, and after each write the destination address moves by one. The step is +1 when the channel's direction input (`src_dec_i`, `dst_dec_i`) was 0 at load and -1 when it was 1. Addresses wrap modulo 2^AW.
- R4: When `src_hold_i` was 1 at load, every read of the block uses the loaded source address, while the destination still steps.
- R5: With `count_i`=C at load, a run copies C+1 bytes. In the cycle after the final write, `done_o` and `tc_o` are both high for exactly one cycle. `busy_o` is high from the first read to the final write and low afterwards.
- R6: With `auto_init_i`=1 at load, terminal count restores the loaded addresses and count, and the block stays armed, so the next `go_i` repeats the identical block. With `auto_init_i`=0, a `go_i` after terminal count is ignored.
- R7: If `eop_i` is high in any cycle of a run, the run ends after the write of the byte in progress. `done_o` then pulses with `tc_o` low. A later `go_i` continues with the next addresses and the remaining count.
- R8: If `eop_i` falls in the final write cycle, the end is treated as terminal count: `tc_o` pulses with `done_o`, and R6 applies.
- R9: `go_i` and `load_i` are ignored while `busy_o` is high, and `eop_i` while idle has no effect on the next run. If `load_i` and `go_i` are high together while idle, the load is taken and the go is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture configuration and arm (idle only) |
| go_i | input | 1 | Start or resume a run (idle and armed only) |
| eop_i | input | 1 | External end of process, stops after current write |
| src_addr_i | input | AW | Source start address |
| dst_addr_i | input | AW | Destination start address |
| count_i | input | CW | Byte count minus one |
| src_dec_i | input | 1 | Source direction, 1 = decrement |
| dst_dec_i | input | 1 | Destination direction, 1 = decrement |
| src_hold_i | input | 1 | 1 = source address fixed |
| auto_init_i | input | 1 | 1 = restore and stay armed at terminal count |
| mem_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data, valid in the read cycle |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The collision case is an external stop that lands in the same write cycle as the terminal count. It is provoked by watching the bus for the write to the last destination address and raising `eop_i` exactly in that cycle. The bench judges it by requiring exactly one `tc_o` pulse together with `done_o` and all bytes present. A following `go_i` must then replay the block from its loaded addresses, which proves the auto-initialize reload still happened. A stop raised one byte earlier, during a read, is the contrasting case: it must yield `done_o` without `tc_o`, and the run must resume where it stopped.

// File: rtl/m2m_pkg.sv
package m2m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned SRC_CH   = 0;
  localparam int unsigned DST_CH   = 1;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/m2m_addr_chan.sv
module m2m_addr_chan #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic          load_dec,
  input  logic          load_hold,
  input  logic          step_en,
  input  logic          reload_en,
  output logic [AW-1:0] cur_addr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] cur_q, cur_d;
  logic          dec_q, dec_d;
  logic          hold_q, hold_d;

  always_comb begin
    base_d = base_q;
    dec_d  = dec_q;
    hold_d = hold_q;
    cur_d  = cur_q;
    if (load_en) begin
      base_d = load_addr;
      dec_d  = load_dec;
      hold_d = load_hold;
      cur_d  = load_addr;
    end else if (reload_en) begin
      cur_d = base_q;
    end else if (step_en && !hold_q) begin
      cur_d = dec_q ? (cur_q - ONE) : (cur_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      dec_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
      dec_q  <= dec_d;
      hold_q <= hold_d;
    end
  end

  assign cur_addr = cur_q;
endmodule

// File: rtl/m2m_word_cnt.sv
module m2m_word_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  input  logic          reload_en,
  output logic          is_last
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] base_q, base_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_en) begin
      base_d = load_val;
      cnt_d  = load_val;
    end else if (reload_en) begin
      cnt_d = base_q;
    end else if (dec_en) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign is_last = (cnt_q == '0);
endmodule

// File: rtl/m2m_seq_ctrl.sv
module m2m_seq_ctrl
  import m2m_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic go_i,
  input  logic eop_i,
  input  logic auto_init_i,
  input  logic cnt_last_i,
  output logic load_en_o,
  output logic rd_act_o,
  output logic wr_act_o,
  output logic cnt_dec_o,
  output logic reload_o,
  output logic busy_o,
  output logic done_o,
  output logic tc_o
);
  seq_state_e state_q, state_d;
  logic armed_q, armed_d;
  logic auto_q, auto_d;
  logic pend_q, pend_d;
  logic done_q, done_d;
  logic tc_q, tc_d;

  logic idle, in_rd, in_wr;
  logic load_acc, go_acc, stop_req, finish, term;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    in_rd    = (state_q == ST_READ);
    in_wr    = (state_q == ST_WRITE);
    load_acc = load_i && idle;
    go_acc   = go_i && !load_i && idle && armed_q;
    stop_req = eop_i || pend_q;
    term     = in_wr && cnt_last_i;
    finish   = in_wr && (cnt_last_i || stop_req);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go_acc) state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = finish ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    if (load_acc) begin
      armed_d = 1'b1;
    end else if (term && !auto_q) begin
      armed_d = 1'b0;
    end
    auto_d = load_acc ? auto_init_i : auto_q;
    pend_d = pend_q;
    if (finish) begin
      pend_d = 1'b0;
    end else if (eop_i && !idle) begin
      pend_d = 1'b1;
    end
    done_d = finish;
    tc_d   = term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      auto_q  <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      auto_q  <= auto_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      tc_q    <= tc_d;
    end
  end

  assign load_en_o = load_acc;
  assign rd_act_o  = in_rd;
  assign wr_act_o  = in_wr;
  assign cnt_dec_o = in_wr && !cnt_last_i;
  assign reload_o  = term && auto_q;
  assign busy_o    = !idle;
  assign done_o    = done_q;
  assign tc_o      = tc_q;
endmodule

// File: rtl/m2m_copy_seq.sv
module m2m_copy_seq
  import m2m_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              go_i,
  input  logic              eop_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [CW-1:0]     count_i,
  input  logic              src_dec_i,
  input  logic              dst_dec_i,
  input  logic              src_hold_i,
  input  logic              auto_init_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tc_o
);
  logic load_en, rd_act, wr_act, cnt_dec, reload, cnt_last;

  logic [AW-1:0] ch_load_addr [NUM_CHAN];
  logic          ch_load_dec  [NUM_CHAN];
  logic          ch_load_hold [NUM_CHAN];
  logic          ch_step      [NUM_CHAN];
  logic [AW-1:0] ch_cur       [NUM_CHAN];

  logic [BYTE_W-1:0] hold_q, hold_d;

  assign ch_load_addr[SRC_CH] = src_addr_i;
  assign ch_load_addr[DST_CH] = dst_addr_i;
  assign ch_load_dec[SRC_CH]  = src_dec_i;
  assign ch_load_dec[DST_CH]  = dst_dec_i;
  assign ch_load_hold[SRC_CH] = src_hold_i;
  assign ch_load_hold[DST_CH] = 1'b0;
  assign ch_step[SRC_CH]      = rd_act;
  assign ch_step[DST_CH]      = wr_act;

  m2m_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .go_i        (go_i),
    .eop_i       (eop_i),
    .auto_init_i (auto_init_i),
    .cnt_last_i  (cnt_last),
    .load_en_o   (load_en),
    .rd_act_o    (rd_act),
    .wr_act_o    (wr_act),
    .cnt_dec_o   (cnt_dec),
    .reload_o    (reload),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .tc_o        (tc_o)
  );

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    m2m_addr_chan #(.AW(AW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_addr (ch_load_addr[g]),
      .load_dec  (ch_load_dec[g]),
      .load_hold (ch_load_hold[g]),
      .step_en   (ch_step[g]),
      .reload_en (reload),
      .cur_addr  (ch_cur[g])
    );
  end

  m2m_word_cnt #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (count_i),
    .dec_en    (cnt_dec),
    .reload_en (reload),
    .is_last   (cnt_last)
  );

  always_comb begin
    hold_d = rd_act ? mem_rdata_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign mem_addr_o  = wr_act ? ch_cur[DST_CH] : ch_cur[SRC_CH];
  assign mem_rd_o    = rd_act;
  assign mem_wr_o    = wr_act;
  assign mem_wdata_o = hold_q;
endmodule

// File: rtl/m2m_copy_chk.sv
module m2m_copy_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] mem_rdata_i,
  input logic [DW-1:0] mem_wdata_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          tc_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> mem_wr_o); // R2
  AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mem_wdata_o == $past(mem_rdata_i))); // R2
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> busy_o); // R1
  AST_TC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> done_o); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_wr_o) && !busy_o)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
endmodule

bind m2m_copy_seq m2m_copy_chk #(.DW(8)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rdata_i (mem_rdata_i),
  .mem_wdata_o (mem_wdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tc_o        (tc_o)
);

// File: tb/sim_m2m_copy_seq.sv
module sim_m2m_copy_seq;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk, rst_n;
  logic load_i, go_i, eop_i;
  logic [AW-1:0] src_addr_i, dst_addr_i;
  logic [CW-1:0] count_i;
  logic src_dec_i, dst_dec_i, src_hold_i, auto_init_i;
  logic [AW-1:0] mem_addr_o;
  logic mem_rd_o, mem_wr_o;
  logic [7:0] mem_rdata_i, mem_wdata_o;
  logic busy_o, done_o, tc_o;

  int n_run, n_fail;
  int cyc;
  int rn, wn, done_cnt, tc_cnt;
  logic [AW-1:0] rd_addr [64];
  logic [AW-1:0] wr_addr [64];
  logic [7:0]    wr_data [64];
  int            rd_cyc  [64];
  int            wr_cyc  [64];

  m2m_copy_seq #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .go_i(go_i), .eop_i(eop_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .count_i(count_i),
    .src_dec_i(src_dec_i), .dst_dec_i(dst_dec_i), .src_hold_i(src_hold_i),
    .auto_init_i(auto_init_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .tc_o(tc_o)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return (a[7:0] * 8'd3 + a[15:8]) ^ 8'h5A;
  endfunction

  assign mem_rdata_i = pat(mem_addr_o);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o && rn < 64) begin
        rd_addr[rn] = mem_addr_o;
        rd_cyc[rn]  = cyc;
        rn++;
      end
      if (mem_wr_o && wn < 64) begin
        wr_addr[wn] = mem_addr_o;
        wr_data[wn] = mem_wdata_o;
        wr_cyc[wn]  = cyc;
        wn++;
      end
      if (done_o) done_cnt++;
      if (tc_o) tc_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_log();
    rn = 0; wn = 0; done_cnt = 0; tc_cnt = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int cnt, input bit sdec, input bit ddec,
                         input bit hold, input bit autoi);
    @(negedge clk);
    src_addr_i = s; dst_addr_i = d; count_i = CW'(cnt);
    src_dec_i = sdec; dst_dec_i = ddec; src_hold_i = hold; auto_init_i = autoi;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_go();
    @(negedge clk);
    clear_log();
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while (done_cnt == 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt != 0, tag, "done seen", done_cnt, 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] b, input int k,
                                             input bit dec);
    return dec ? (b - AW'(k)) : (b + AW'(k));
  endfunction

  task automatic verify_block(input string tag, input logic [AW-1:0] s,
                              input logic [AW-1:0] d, input int n, input int off,
                              input bit sdec, input bit ddec, input bit hold,
                              input int exp_tc);
    logic [AW-1:0] es, ed;
    chk(rn == n, tag, "read count", rn, n);
    chk(wn == n, tag, "write count", wn, n);
    for (int i = 0; i < n && i < rn && i < wn; i++) begin
      es = hold ? s : stepped(s, off + i, sdec);
      ed = stepped(d, off + i, ddec);
      chk(rd_addr[i] == es, tag, "read addr", rd_addr[i], es);
      chk(wr_addr[i] == ed, tag, "write addr", wr_addr[i], ed);
      chk(wr_data[i] == pat(es), tag, "write data", wr_data[i], pat(es));
      chk(wr_cyc[i] == rd_cyc[i] + 1, tag, "write follows read", wr_cyc[i], rd_cyc[i] + 1);
    end
    chk(done_cnt == 1, tag, "done pulses", done_cnt, 1);
    chk(tc_cnt == exp_tc, tag, "tc pulses", tc_cnt, exp_tc);
    chk(busy_o == 1'b0, tag, "busy after end", busy_o, 0);
  endtask

  task automatic t_reset();
    chk(!mem_rd_o && !mem_wr_o, "R1", "strobes at reset", {mem_rd_o, mem_wr_o}, 0);
    chk(!busy_o && !done_o && !tc_o, "R1", "status at reset", {busy_o, done_o, tc_o}, 0);
    do_go();
    repeat (10) @(negedge clk);
    chk(rn == 0 && wn == 0, "R1", "go before load bus cycles", rn + wn, 0);
    chk(done_cnt == 0, "R1", "go before load done", done_cnt, 0);
  endtask

  task automatic t_basic();
    do_load(16'h1000, 16'h2040, 4, 1'b0, 1'b0, 1'b0, 1'b0);
    do_go();
    wait_done("R5");
    verify_block("R2", 16'h1000, 16'h2040, 5, 0, 1'b0, 1'b0, 1'b0, 1);
    do_go();
    repeat (10) @(negedge clk);
    chk(rn == 0 && done_cnt == 0, "R6", "go after tc without auto-init", rn + done_cnt, 0);
    do_load(16'h0500, 16'h0600, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    do_go();
    wait_done("R5");
    verify_block("R5", 16'h0500, 16'h0600, 1, 0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  task automatic t_dirs();
    do_load(16'h0002, 16'h3000, 5, 1'b1, 1'b0, 1'b0, 1'b0);
    do_go();
    wait_done("R3");
    verify_block("R3", 16'h0002, 16'h3000, 6, 0, 1'b1, 1'b0, 1'b0, 1);
    chk(rd_addr[3] == 16'hFFFF, "R3", "source wrap", rd_addr[3], 16'hFFFF);
  endtask

  task automatic t_hold();
    do_load(16'h0123, 16'h4005, 4, 1'b0, 1'b1, 1'b1, 1'b0);
    do_go();
    wait_done("R4");
    verify_block("R4", 16'h0123, 16'h4005, 5, 0, 1'b0, 1'b1, 1'b1, 1);
  endtask

  task automatic t_auto();
    do_load(16'h0700, 16'h0900, 2, 1'b0, 1'b0, 1'b0, 1'b1);
    do_go();
    wait_done("R6");
    verify_block("R6", 16'h0700, 16'h0900, 3, 0, 1'b0, 1'b0, 1'b0, 1);
    do_go();
    wait_done("R6");
    verify_block("R6", 16'h0700, 16'h0900, 3, 0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  task automatic t_eop();
    int t;
    do_load(16'h1100, 16'h1200, 5, 1'b0, 1'b0, 1'b0, 1'b0);
    do_go();
    t = 0;
    while (!(mem_rd_o && mem_addr_o == 16'h1101) && t < 100) begin
      @(negedge clk);
      t++;
    end
    eop_i = 1'b1;
    @(negedge clk);
    eop_i = 1'b0;
    wait_done("R7");
    verify_block("R7", 16'h1100, 16'h1200, 2, 0, 1'b0, 1'b0, 1'b0, 0);
    do_go();
    wait_done("R7");
    verify_block("R7", 16'h1100, 16'h1200, 4, 2, 1'b0, 1'b0, 1'b0, 1);
  endtask

  task automatic t_collide();
    int t;
    do_load(16'h2200, 16'h2300, 2, 1'b0, 1'b0, 1'b0, 1'b1);
    do_go();
    t = 0;
    while (!(mem_wr_o && mem_addr_o == 16'h2302) && t < 100) begin
      @(negedge clk);
      t++;
    end
    eop_i = 1'b1;
    @(negedge clk);
    eop_i = 1'b0;
    wait_done("R8");
    verify_block("R8", 16'h2200, 16'h2300, 3, 0, 1'b0, 1'b0, 1'b0, 1);
    do_go();
    wait_done("R8");
    verify_block("R8", 16'h2200, 16'h2300, 3, 0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  task automatic t_ignore();
    int t;
    do_load(16'h0300, 16'h0380, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    eop_i = 1'b1;
    @(negedge clk);
    eop_i = 1'b0;
    do_go();
    t = 0;
    while (!mem_rd_o && t < 50) begin
      @(negedge clk);
      t++;
    end
    go_i = 1'b1; load_i = 1'b1; src_addr_i = 16'h7777; count_i = 16'd9;
    @(negedge clk);
    go_i = 1'b0; load_i = 1'b0;
    wait_done("R9");
    verify_block("R9", 16'h0300, 16'h0380, 4, 0, 1'b0, 1'b0, 1'b0, 1);
    @(negedge clk);
    clear_log();
    src_addr_i = 16'h0A00; dst_addr_i = 16'h0B00; count_i = 16'd1;
    src_dec_i = 1'b0; dst_dec_i = 1'b0; src_hold_i = 1'b0; auto_init_i = 1'b0;
    load_i = 1'b1; go_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; go_i = 1'b0;
    repeat (8) @(negedge clk);
    chk(rn == 0 && done_cnt == 0, "R9", "go with load dropped", rn + done_cnt, 0);
    do_go();
    wait_done("R9");
    verify_block("R9", 16'h0A00, 16'h0B00, 2, 0, 1'b0, 1'b0, 1'b0, 1);
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    rn = 0; wn = 0; done_cnt = 0; tc_cnt = 0;
    rst_n = 1'b0;
    load_i = 1'b0; go_i = 1'b0; eop_i = 1'b0;
    src_addr_i = '0; dst_addr_i = '0; count_i = '0;
    src_dec_i = 1'b0; dst_dec_i = 1'b0; src_hold_i = 1'b0; auto_init_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dirs();
    t_hold();
    t_auto();
    t_eop();
    t_collide();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule